// File: doc/BRIEF.md
# Protected Command Sequence Decoder

This block sits on the write path of a flash controller and looks at every byte write presented to it (an address and a data byte). Destructive and mode-changing operations are guarded: they are only recognised after a fixed series of unlock writes, each with an exact address and an exact data byte. When a series completes, the block issues one operation request for a single cycle. The request carries an operation code, the address of the final write and its data byte.

Writes that arrive while the `busy` input is high are ignored. They do not advance the sequence and they do not break it. Any accepted write that does not fit the step the decoder is waiting for sends it back to idle and issues nothing. The decoder also holds an identification-mode flag. While that flag is set, the identification byte output returns the device code.

Top module: `cmd_seq_decoder`

## Requirements
- R1: The accepted writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any accepted write, issue a byte-program request. The request has `req_op`=1 and the address and data of the fourth write. `req_valid` is high for exactly the one cycle after the edge that accepts the final write.
- R2: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. When it is followed by a sixth write with data 30h, the block issues a sector-erase request (`req_op`=2) with that write's address and data.
- R3: The erase prefix followed by a sixth write with data 50h issues a block-erase request (`req_op`=3) with that write's address.
- R4: The erase prefix followed by data 10h issues a chip-erase request (`req_op`=4) only when `pp_mode` is 1. When `pp_mode` is 0 the sequence ends with no request.
- R5: AAh@5555h, 55h@2AAAh, 90h@5555h issues an ID-entry request (`req_op`=5) and sets `id_mode`. While `id_mode` is 1, `id_byte` reads 53h; otherwise `id_byte` reads 00h.
- R6: AAh@5555h, 55h@2AAAh, F0h@5555h issues an ID-exit request (`req_op`=6) and clears `id_mode`.
- R7: Only the low 15 address bits take part in the 5555h and 2AAAh comparisons. The upper bits may hold any value.
- R8: An accepted write that does not match the current step returns the decoder to idle and issues no request. A later write that would have completed the broken sequence issues nothing.
- R9: A write presented while `busy` is 1 is ignored. It neither advances nor resets the sequence, and it never causes a request.
- R10: A sixth erase write whose data is not 30h, 50h or 10h aborts the sequence without a request.
- R11: After reset, `req_valid` is 0, `id_mode` is 0 and `id_byte` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | An operation is running; writes are ignored |
| pp_mode | input | 1 | 1 = programmer mode, chip erase allowed |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 ID entry, 6 ID exit |
| req_addr | output | ADDR_W | Address of the completing write |
| req_data | output | 8 | Data of the completing write |
| id_mode | output | 1 | Identification mode is active |
| id_byte | output | 8 | 53h in identification mode, else 00h |

## Verification
Every request appears exactly one clock after the edge that accepts the completing write. The `id_mode` flag changes on that same edge. The bench drives each write on a falling edge and holds it for one full cycle. On the following falling edge it compares the request against the head of an expected-item queue. Any request that arrives when the queue is empty is a failure. After each scenario the bench confirms that the queue has drained. Aborted and ignored sequences are checked by sending the write that would have completed them and then confirming that no request appears.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SECT   = 3'd2,
    OP_BLOCK  = 3'd3,
    OP_CHIP   = 3'd4,
    OP_ID_IN  = 3'd5,
    OP_ID_OUT = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_PROG,
    ST_E3,
    ST_E4,
    ST_E5
  } step_e;

endpackage

// File: rtl/cseq_match.sv
module cseq_match #(
  parameter int ADDR_W = 24,
  parameter int CMP_W  = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              at_a,
  output logic              key1,
  output logic              key2
);
  localparam logic [CMP_W-1:0] ADDR_A = CMP_W'(16'h5555);
  localparam logic [CMP_W-1:0] ADDR_B = CMP_W'(16'h2AAA);

  logic at_b;

  always_comb begin
    at_a = (addr[CMP_W-1:0] == ADDR_A);
    at_b = (addr[CMP_W-1:0] == ADDR_B);
    key1 = at_a && (data == 8'hAA);
    key2 = at_b && (data == 8'h55);
  end
endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
  import cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] data,
  input  logic       at_a,
  input  logic       key1,
  input  logic       key2,
  input  logic       pp_mode,
  output logic       issue,
  output op_e        issue_op
);
  step_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    issue    = 1'b0;
    issue_op = OP_NONE;
    if (step) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (key1) st_d = ST_K1;
        ST_K1:   if (key2) st_d = ST_K2;
        ST_K2: begin
          if (at_a) begin
            unique case (data)
              8'hA0: st_d = ST_PROG;
              8'h80: st_d = ST_E3;
              8'h90: begin issue = 1'b1; issue_op = OP_ID_IN;  end
              8'hF0: begin issue = 1'b1; issue_op = OP_ID_OUT; end
              default: st_d = ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin issue = 1'b1; issue_op = OP_PROG; end
        ST_E3:   if (key1) st_d = ST_E4;
        ST_E4:   if (key2) st_d = ST_E5;
        ST_E5: begin
          unique case (data)
            8'h30: begin issue = 1'b1; issue_op = OP_SECT;  end
            8'h50: begin issue = 1'b1; issue_op = OP_BLOCK; end
            8'h10: begin issue = pp_mode; issue_op = pp_mode ? OP_CHIP : OP_NONE; end
            default: issue = 1'b0;
          endcase
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else if (step) st_q <= st_d;
  end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cseq_pkg::*;
#(
  parameter int          ADDR_W = 24,
  parameter int          CMP_W  = 15,
  parameter logic [7:0]  DEV_ID = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              pp_mode,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              id_mode,
  output logic [7:0]        id_byte
);
  logic step, at_a, key1, key2, issue;
  op_e  issue_op;
  logic id_mode_d;

  assign step = wr_valid && !busy;

  cseq_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
    .addr (wr_addr),
    .data (wr_data),
    .at_a (at_a),
    .key1 (key1),
    .key2 (key2)
  );

  cseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .data     (wr_data),
    .at_a     (at_a),
    .key1     (key1),
    .key2     (key2),
    .pp_mode  (pp_mode),
    .issue    (issue),
    .issue_op (issue_op)
  );

  always_comb begin
    id_mode_d = id_mode;
    if (issue && issue_op == OP_ID_IN)  id_mode_d = 1'b1;
    if (issue && issue_op == OP_ID_OUT) id_mode_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      id_mode   <= 1'b0;
    end else begin
      req_valid <= issue;
      id_mode   <= id_mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_op   <= 3'd0;
      req_addr <= '0;
      req_data <= 8'h00;
    end else if (issue) begin
      req_op   <= issue_op;
      req_addr <= wr_addr;
      req_data <= wr_data;
    end
  end

  assign id_byte = id_mode ? DEV_ID : 8'h00;
endmodule

// File: rtl/cseq_checker.sv
module cseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       busy,
  input logic       pp_mode,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       id_mode
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_chip_needs_pp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> $past(pp_mode));

  assert_id_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (req_valid && req_op == 3'd5));

  assert_id_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> (req_valid && req_op == 3'd6));

  assert_no_write_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !req_valid);

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !req_valid);

  assert_op_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op >= 3'd1 && req_op <= 3'd6));
endmodule

bind cmd_seq_decoder cseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .busy      (busy),
  .pp_mode   (pp_mode),
  .req_valid (req_valid),
  .req_op    (req_op),
  .id_mode   (id_mode)
);

// File: tb/cmd_seq_decoder_bench.sv
module cmd_seq_decoder_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          busy;
  logic          pp_mode;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          id_mode;
  logic [7:0]    id_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [2:0] op; logic [AW-1:0] addr; logic [7:0] data; string tag; } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  cmd_seq_decoder u_cmd_seq_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .pp_mode(pp_mode), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .id_mode(id_mode), .id_byte(id_byte)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Driver: one write, presented for one cycle starting on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit b = 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic expect_req(input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [7:0] d, input string tag);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic drained(input string tag);
    @(negedge clk); @(negedge clk);
    check(expq.size() == 0, tag,
          $sformatf("pending expected=%0d actual=0", expq.size()));
    expq.delete();
  endtask

  task automatic unlock3(input logic [7:0] code);
    wr(24'h005555, 8'hAA);
    wr(24'h002AAA, 8'h55);
    wr(24'h005555, code);
  endtask

  task automatic erase_prefix();
    unlock3(8'h80);
    wr(24'h005555, 8'hAA);
    wr(24'h002AAA, 8'h55);
  endtask

  // Monitor: compare each request against the queue head
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req_valid === 1'b1) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8", $sformatf("unexpected request op=%0d addr=%h actual, expected none",
                                    req_op, req_addr));
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(req_op == e.op && req_addr == e.addr && req_data == e.data, e.tag,
              $sformatf("actual op=%0d addr=%h data=%h expected op=%0d addr=%h data=%h",
                        req_op, req_addr, req_data, e.op, e.addr, e.data));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; pp_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid == 0 && id_mode == 0 && id_byte == 8'h00, "R11",
          $sformatf("actual v=%b id=%b byte=%h expected 0 0 00", req_valid, id_mode, id_byte));

    // R1 program
    expect_req(3'd1, 24'h012345, 8'h3C, "R1");
    unlock3(8'hA0); wr(24'h012345, 8'h3C);
    drained("R1");

    // R2 sector erase
    expect_req(3'd2, 24'h071000, 8'h30, "R2");
    erase_prefix(); wr(24'h071000, 8'h30);
    drained("R2");

    // R3 block erase
    expect_req(3'd3, 24'h050000, 8'h50, "R3");
    erase_prefix(); wr(24'h050000, 8'h50);
    drained("R3");

    // R4 chip erase rejected then accepted
    pp_mode = 1'b0;
    erase_prefix(); wr(24'h005555, 8'h10);
    drained("R4");
    pp_mode = 1'b1;
    expect_req(3'd4, 24'h005555, 8'h10, "R4");
    erase_prefix(); wr(24'h005555, 8'h10);
    drained("R4");
    pp_mode = 1'b0;

    // R5 ID entry
    expect_req(3'd5, 24'h005555, 8'h90, "R5");
    unlock3(8'h90);
    check(id_mode == 1 && id_byte == 8'h53, "R5",
          $sformatf("actual id=%b byte=%h expected 1 53", id_mode, id_byte));
    drained("R5");

    // R6 ID exit
    expect_req(3'd6, 24'h005555, 8'hF0, "R6");
    unlock3(8'hF0);
    check(id_mode == 0 && id_byte == 8'h00, "R6",
          $sformatf("actual id=%b byte=%h expected 0 00", id_mode, id_byte));
    drained("R6");

    // R7 upper address bits ignored
    expect_req(3'd1, 24'h0000AB, 8'h5A, "R7");
    wr(24'hFFD555, 8'hAA); wr(24'hAB2AAA, 8'h55); wr(24'h80D555, 8'hA0);
    wr(24'h0000AB, 8'h5A);
    drained("R7");

    // R8 wrong address breaks the sequence
    wr(24'h005555, 8'hAA); wr(24'h002AAB, 8'h55); wr(24'h005555, 8'hA0);
    wr(24'h000100, 8'h77);
    drained("R8");
    wr(24'h005555, 8'hAA); wr(24'h002AAA, 8'h55); wr(24'h005555, 8'h91);
    wr(24'h000100, 8'h77);
    drained("R8");

    // R9 busy writes neither advance nor break
    expect_req(3'd1, 24'h000200, 8'hC3, "R9");
    wr(24'h005555, 8'hAA);
    wr(24'h000000, 8'h12, 1'b1);
    wr(24'h002AAA, 8'h55);
    wr(24'h005555, 8'hAA, 1'b1);
    wr(24'h005555, 8'hA0);
    wr(24'h000300, 8'hEE, 1'b1);
    wr(24'h000200, 8'hC3);
    drained("R9");
    unlock3(8'hA0); wr(24'h000400, 8'h11, 1'b1);
    drained("R9");
    expect_req(3'd1, 24'h000500, 8'h22, "R9");
    wr(24'h000500, 8'h22);
    drained("R9");

    // R10 bad erase code
    erase_prefix(); wr(24'h071000, 8'h40);
    wr(24'h071000, 8'h30);
    drained("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule